// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two binary32 floating-point words and returns a binary32 result through an output register. Each operand is split into sign, exponent and significand. A magnitude comparator then steers a bank of multiplexers so that the larger operand always takes the leading path. The smaller significand is shifted right to line up with the larger one, and guard, round and sticky bits are kept during the shift. The two significands are then summed or differenced. The raw result is normalized either to the right (after a carry) or to the left (after cancellation), rounded to nearest with ties to even, and packed back into a word.

The block has a bypass for a zero operand, which sends the other operand straight to the result and skips the arithmetic path. Special values (infinity and NaN) are resolved ahead of the datapath. Denormal inputs are treated as zero, and results too small for a normal exponent become zero. The caller presents both operands and a subtract select together with a valid strobe. The answer is available after the next rising clock edge.

Top module: `fpadd_sp`

## Requirements
- R1: After reset, `res_word` is 0x00000000 and `res_valid` is 0. Any clock edge at which `in_valid` is low loads 0x00000000 into `res_word` and clears `res_valid`, whatever the operand inputs are.
- R2: Operands sampled with `in_valid` high at a rising edge produce their result on `res_word`, with `res_valid` high, immediately after that same edge. Before that edge the output still shows the previous contents.
- R3: An operand whose exponent field (bits 30:23) is zero takes the bypass. With only `opnd_a` zero, the result is `opnd_b` with bit 31 inverted when `op_sub` is 1. With only `opnd_b` zero, the result is `opnd_a`. With both zero, the result is a zero whose sign bit is sign(a) AND effective sign(b).
- R4: An operand with exponent field zero and a nonzero fraction (a denormal) behaves exactly as a zero of the same sign.
- R5: For two normal operands, the result has the sign of the operand with the larger magnitude after `op_sub` has been applied to b. Results that are exactly representable are returned exactly.
- R6: Alignment keeps guard, round and sticky information, and rounding is to nearest with ties to even. For example, 0x3F800000 + 0x33800000 = 0x3F800000, 0x3F800001 + 0x33800000 = 0x3F800002, and 0x3F800000 + 0x33C00000 = 0x3F800001.
- R7: After cancellation, the result is shifted left until it is normalized and the exponent is reduced to match (0x3F800001 - 0x3F800000 = 0x34000000). An exact cancellation gives +0 (0x00000000).
- R8: A carry out of the significand sum shifts the result right by one place and raises the exponent by one (0x3FFFFFFF + 0x3FFFFFFF = 0x407FFFFF).
- R9: A result exponent of 255 or more gives infinity with the result sign: 0x7F800000 or 0xFF800000.
- R10: A nonzero result whose exponent would be 0 or less gives 0x00000000. The block never outputs a nonzero fraction with a zero exponent field.
- R11: An infinite operand (exponent 255, fraction 0), combined with a finite operand or with an infinity of the same effective sign, gives infinity with that operand's effective sign.
- R12: A NaN operand (exponent 255, fraction nonzero), or two infinities of opposite effective sign, gives the quiet NaN 0x7FC00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and select are valid in this cycle |
| op_sub | input | 1 | 1 selects a - b, 0 selects a + b |
| opnd_a | input | 32 | First operand, binary32 |
| opnd_b | input | 32 | Second operand, binary32 |
| res_valid | output | 1 | Registered copy of `in_valid` |
| res_word | output | 32 | Registered result, zero when idle |

## Verification
Each result is due exactly one rising edge after its operands are sampled. The bench drives operands on the falling edge and reads `res_word` and `res_valid` on the next falling edge, so each result is read half a period after the edge that captured it. The latency check also reads the output just before the capturing edge, to confirm it still holds the old value. An idle check drives junk operands with `in_valid` low and expects zero on the following falling edge.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

   // Classification of an unpacked operand
   typedef enum logic [1:0] {
      FK_NUM  = 2'd0,
      FK_ZERO = 2'd1,
      FK_INF  = 2'd2,
      FK_NAN  = 2'd3
   } fp_kind_e;

   // Number of bits needed to hold values 0..n
   function automatic int cnt_bits(input int n);
      int b;
      b = 1;
      while ((1 << b) <= n) b++;
      return b;
   endfunction

endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack
   import fpa_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int W    = 1 + EXP_W + MAN_W
) (
   input  logic [W-1:0]     word,
   output logic             sgn,
   output logic [EXP_W-1:0] expo,
   output logic [MAN_W:0]   sig,
   output fp_kind_e         kind
);

   logic [MAN_W-1:0] frac;
   logic             exp_zero;
   logic             exp_full;

   assign sgn      = word[W-1];
   assign expo     = word[W-2:MAN_W];
   assign frac     = word[MAN_W-1:0];
   assign exp_zero = (expo == '0);
   assign exp_full = (expo == '1);

   // hidden one restored for normal numbers; denormals collapse to zero
   assign sig = exp_zero ? '0 : {1'b1, frac};

   always_comb begin
      if (exp_zero)           kind = FK_ZERO;
      else if (!exp_full)     kind = FK_NUM;
      else if (frac == '0)    kind = FK_INF;
      else                    kind = FK_NAN;
   end

endmodule

// File: rtl/fpa_order_align.sv
module fpa_order_align
   import fpa_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int EXT  = MAN_W + 4,
   localparam int SH_W = cnt_bits(EXT)
) (
   input  logic             a_sgn,
   input  logic [EXP_W-1:0] a_exp,
   input  logic [MAN_W:0]   a_sig,
   input  logic             b_sgn,
   input  logic [EXP_W-1:0] b_exp,
   input  logic [MAN_W:0]   b_sig,
   output logic             big_sgn,
   output logic [EXP_W-1:0] big_exp,
   output logic [EXT-1:0]   big_ext,
   output logic [EXT-1:0]   sml_ext,
   output logic             eff_sub
);

   logic             a_leads;
   logic [EXP_W-1:0] sml_exp;
   logic [MAN_W:0]   sml_sig;
   logic [MAN_W:0]   big_sig;
   logic [EXP_W-1:0] exp_gap;
   logic [SH_W-1:0]  shamt;

   // magnitude comparator on exponent then fraction
   assign a_leads = {a_exp, a_sig[MAN_W-1:0]} >= {b_exp, b_sig[MAN_W-1:0]};

   // swap multiplexers
   assign big_sgn = a_leads ? a_sgn : b_sgn;
   assign big_exp = a_leads ? a_exp : b_exp;
   assign big_sig = a_leads ? a_sig : b_sig;
   assign sml_exp = a_leads ? b_exp : a_exp;
   assign sml_sig = a_leads ? b_sig : a_sig;
   assign eff_sub = a_sgn ^ b_sgn;

   assign big_ext = {big_sig, 3'b000};

   // clamp the distance: anything past the window becomes pure sticky
   assign exp_gap = big_exp - sml_exp;
   assign shamt   = (int'(exp_gap) > EXT) ? SH_W'(EXT) : SH_W'(exp_gap);

   // logarithmic right shifter with sticky collection per stage
   logic [EXT-1:0] stg [0:SH_W];
   assign stg[0] = {sml_sig, 3'b000};

   for (genvar k = 0; k < SH_W; k++) begin : g_stage
      localparam int STEP = 1 << k;
      logic lost;
      assign lost       = |stg[k][STEP-1:0];
      assign stg[k+1]   = shamt[k] ? ((stg[k] >> STEP) | {{(EXT-1){1'b0}}, lost})
                                   : stg[k];
   end

   assign sml_ext = stg[SH_W];

endmodule

// File: rtl/fpa_addnorm_round.sv
module fpa_addnorm_round
   import fpa_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int W    = 1 + EXP_W + MAN_W,
   localparam int EXT  = MAN_W + 4,
   localparam int LZ_W = cnt_bits(EXT),
   localparam int XW   = EXP_W + 2
) (
   input  logic             big_sgn,
   input  logic [EXP_W-1:0] big_exp,
   input  logic [EXT-1:0]   big_ext,
   input  logic [EXT-1:0]   sml_ext,
   input  logic             eff_sub,
   output logic [W-1:0]     res
);

   localparam logic signed [XW-1:0] E_TOP = XW'((1 << EXP_W) - 1);
   localparam logic signed [XW-1:0] E_ONE = XW'(1);

   logic [EXT:0]           raw;
   logic [LZ_W-1:0]        lz;
   logic [EXT-1:0]         norm;
   logic signed [XW-1:0]   e_big;
   logic signed [XW-1:0]   e_norm;
   logic signed [XW-1:0]   e_fin;
   logic signed [XW-1:0]   lz_x;
   logic [MAN_W:0]         keep;
   logic                   g_bit, r_bit, s_bit, rnd_up;
   logic [MAN_W+1:0]       rnd;
   logic                   rnd_ovf;
   logic [MAN_W-1:0]       frac;

   assign raw = eff_sub ? ({1'b0, big_ext} - {1'b0, sml_ext})
                        : ({1'b0, big_ext} + {1'b0, sml_ext});

   // leading-zero count over the low EXT bits (highest set bit wins)
   always_comb begin
      lz = LZ_W'(EXT);
      for (int i = 0; i < EXT; i++) begin
         if (raw[i]) lz = LZ_W'(EXT - 1 - i);
      end
   end

   assign e_big = XW'(big_exp);
   assign lz_x  = XW'(lz);

   // bidirectional normalization
   always_comb begin
      if (raw[EXT]) begin
         norm   = {raw[EXT:2], raw[1] | raw[0]};
         e_norm = e_big + E_ONE;
      end else begin
         norm   = raw[EXT-1:0] << lz;
         e_norm = e_big - lz_x;
      end
   end

   // round to nearest, ties to even
   assign keep    = norm[EXT-1:3];
   assign g_bit   = norm[2];
   assign r_bit   = norm[1];
   assign s_bit   = norm[0];
   assign rnd_up  = g_bit & (r_bit | s_bit | keep[0]);
   assign rnd     = {1'b0, keep} + (MAN_W+2)'(rnd_up);
   assign rnd_ovf = rnd[MAN_W+1];
   assign e_fin   = rnd_ovf ? (e_norm + E_ONE) : e_norm;
   assign frac    = rnd_ovf ? rnd[MAN_W:1] : rnd[MAN_W-1:0];

   always_comb begin
      if (raw == '0)
         res = '0;
      else if (e_fin >= E_TOP)
         res = {big_sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
      else if (e_fin < E_ONE)
         res = '0;
      else
         res = {big_sgn, e_fin[EXP_W-1:0], frac};
   end

endmodule

// File: rtl/fpadd_sp.sv
module fpadd_sp
   import fpa_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int W    = 1 + EXP_W + MAN_W,
   localparam int EXT  = MAN_W + 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic         op_sub,
   input  logic [W-1:0] opnd_a,
   input  logic [W-1:0] opnd_b,
   output logic         res_valid,
   output logic [W-1:0] res_word
);

   // elaboration-time parameter checks
   if (EXP_W < 3) begin : g_bad_exp
      $error("fpadd_sp: EXP_W must be at least 3");
   end
   if (MAN_W < 3) begin : g_bad_man
      $error("fpadd_sp: MAN_W must be at least 3");
   end

   localparam logic [W-1:0] QNAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
   localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};

   logic             a_sgn, b_sgn, b_eff;
   logic [EXP_W-1:0] a_exp, b_exp;
   logic [MAN_W:0]   a_sig, b_sig;
   fp_kind_e         a_kind, b_kind;

   fpa_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unp_a (
      .word (opnd_a), .sgn (a_sgn), .expo (a_exp), .sig (a_sig), .kind (a_kind)
   );

   fpa_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unp_b (
      .word (opnd_b), .sgn (b_sgn), .expo (b_exp), .sig (b_sig), .kind (b_kind)
   );

   assign b_eff = b_sgn ^ op_sub;

   logic             big_sgn, eff_sub;
   logic [EXP_W-1:0] big_exp;
   logic [EXT-1:0]   big_ext, sml_ext;
   logic [W-1:0]     dp_res;

   fpa_order_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
      .a_sgn   (a_sgn),   .a_exp   (a_exp),   .a_sig   (a_sig),
      .b_sgn   (b_eff),   .b_exp   (b_exp),   .b_sig   (b_sig),
      .big_sgn (big_sgn), .big_exp (big_exp), .big_ext (big_ext),
      .sml_ext (sml_ext), .eff_sub (eff_sub)
   );

   fpa_addnorm_round #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_arith (
      .big_sgn (big_sgn), .big_exp (big_exp), .big_ext (big_ext),
      .sml_ext (sml_ext), .eff_sub (eff_sub), .res     (dp_res)
   );

   // special values and zero bypass ahead of the datapath result
   logic [W-1:0] nxt;
   always_comb begin
      if (a_kind == FK_NAN || b_kind == FK_NAN ||
          (a_kind == FK_INF && b_kind == FK_INF && a_sgn != b_eff))
         nxt = QNAN;
      else if (a_kind == FK_INF)
         nxt = {a_sgn, INF_MAG};
      else if (b_kind == FK_INF)
         nxt = {b_eff, INF_MAG};
      else if (a_kind == FK_ZERO && b_kind == FK_ZERO)
         nxt = {a_sgn & b_eff, {(W-1){1'b0}}};
      else if (a_kind == FK_ZERO)
         nxt = {b_eff, opnd_b[W-2:0]};
      else if (b_kind == FK_ZERO)
         nxt = opnd_a;
      else
         nxt = dp_res;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_word  <= '0;
      end else begin
         res_valid <= in_valid;
         res_word  <= in_valid ? nxt : '0;
      end
   end

endmodule

// File: rtl/fpadd_sp_chk.sv
module fpadd_sp_chk #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int W    = 1 + EXP_W + MAN_W
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_valid,
   input logic         op_sub,
   input logic [W-1:0] opnd_a,
   input logic [W-1:0] opnd_b,
   input logic         res_valid,
   input logic [W-1:0] res_word
);

   localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   logic a_zero, b_zero, a_nan, b_nan, a_inf, b_inf;
   assign a_zero = (opnd_a[W-2:MAN_W] == '0);
   assign b_zero = (opnd_b[W-2:MAN_W] == '0);
   assign a_nan  = (opnd_a[W-2:MAN_W] == '1) && (opnd_a[MAN_W-1:0] != '0);
   assign b_nan  = (opnd_b[W-2:MAN_W] == '1) && (opnd_b[MAN_W-1:0] != '0);
   assign a_inf  = (opnd_a[W-2:MAN_W] == '1) && (opnd_a[MAN_W-1:0] == '0);
   assign b_inf  = (opnd_b[W-2:MAN_W] == '1) && (opnd_b[MAN_W-1:0] == '0);

   // R1: idle cycle clears the output
   p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (res_word == '0) && !res_valid);

   // R2: valid result one edge after the operands
   p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid);

   // R3: a zero first operand forwards the sign-adjusted second operand
   p_bypass_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && a_zero && !b_zero && !b_nan && !b_inf) |=>
         res_word == {$past(opnd_b[W-1] ^ op_sub), $past(opnd_b[W-2:0])});

   // R3: a zero second operand forwards the first operand
   p_bypass_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && b_zero && !a_zero && !a_nan && !a_inf) |=>
         res_word == $past(opnd_a));

   // R10: never a denormal on the output
   p_no_denormal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (res_word[W-2:MAN_W] == '0) |-> (res_word[MAN_W-1:0] == '0));

   // R11: infinite first operand with finite second operand
   p_inf_prop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && a_inf && !b_inf && !b_nan) |=>
         res_word == {$past(opnd_a[W-1]), {EXP_W{1'b1}}, {MAN_W{1'b0}}});

   // R12: NaN input gives the canonical quiet NaN
   p_nan_out_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (a_nan || b_nan)) |=> res_word == QNAN);

endmodule

bind fpadd_sp fpadd_sp_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_sub    (op_sub),
   .opnd_a    (opnd_a),
   .opnd_b    (opnd_b),
   .res_valid (res_valid),
   .res_word  (res_word)
);

// File: tb/fpadd_sp_tb.sv
`timescale 1ns/100ps
module fpadd_sp_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        op_sub = 1'b0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic        res_valid;
   logic [31:0] res_word;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   fpadd_sp u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .op_sub    (op_sub),
      .opnd_a    (opnd_a),
      .opnd_b    (opnd_b),
      .res_valid (res_valid),
      .res_word  (res_word)
   );

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // drive at a falling edge, read one full period later
   task automatic run(input logic [31:0] a, input logic [31:0] b,
                      input bit sub, input logic [31:0] exp, input string req);
      opnd_a   = a;
      opnd_b   = b;
      op_sub   = sub;
      in_valid = 1'b1;
      @(negedge clk);
      check(res_valid && res_word == exp, req, res_word, exp);
   endtask

   // binary32 encoding of a small non-negative integer
   function automatic logic [31:0] enc(input int n);
      int p;
      if (n == 0) return 32'h0;
      p = 0;
      while ((n >> (p + 1)) != 0) p++;
      return {1'b0, 8'(127 + p), 23'((n << (23 - p)) & 32'h7FFFFF)};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(res_word == 32'h0 && !res_valid, "R1", res_word, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: output unchanged before the capturing edge, updated after
      opnd_a = 32'h3F800000; opnd_b = 32'h3F800000; op_sub = 1'b0; in_valid = 1'b1;
      @(posedge clk); #1;
      @(negedge clk); #1.2;
      in_valid = 1'b0;
      @(negedge clk);
      opnd_a = 32'h40400000; opnd_b = 32'h3F800000; in_valid = 1'b1;
      #2.0;
      check(res_word == 32'h0, "R2", res_word, 32'h0);
      @(negedge clk);
      check(res_valid && res_word == 32'h40800000, "R2", res_word, 32'h40800000);

      // R1: idle with junk operands
      opnd_a = 32'h12345678; opnd_b = 32'h7FC00000; in_valid = 1'b0;
      @(negedge clk);
      check(res_word == 32'h0 && !res_valid, "R1", res_word, 32'h0);

      // R3: bypass
      run(32'h00000000, 32'h40490FDB, 1'b0, 32'h40490FDB, "R3");
      run(32'h00000000, 32'h40490FDB, 1'b1, 32'hC0490FDB, "R3");
      run(32'hC1200000, 32'h80000000, 1'b1, 32'hC1200000, "R3");
      run(32'h80000000, 32'h80000000, 1'b0, 32'h80000000, "R3");
      run(32'h80000000, 32'h00000000, 1'b1, 32'h80000000, "R3");
      run(32'h00000000, 32'h00000000, 1'b1, 32'h00000000, "R3");

      // R4: denormals act as zero
      run(32'h00000001, 32'h3F800000, 1'b0, 32'h3F800000, "R4");
      run(32'h80400000, 32'h40000000, 1'b1, 32'hC0000000, "R4");
      run(32'h3F800000, 32'h007FFFFF, 1'b1, 32'h3F800000, "R4");

      // R5: ordinary sums and differences
      run(32'h3FC00000, 32'h40100000, 1'b0, 32'h40700000, "R5");
      run(32'h40000000, 32'h40400000, 1'b1, 32'hBF800000, "R5");
      run(32'hC0A00000, 32'h40400000, 1'b0, 32'hC0000000, "R5");

      // R6: rounding
      run(32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, "R6");
      run(32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, "R6");
      run(32'h3F800000, 32'h33C00000, 1'b0, 32'h3F800001, "R6");
      run(32'h3F800000, 32'h00800000, 1'b0, 32'h3F800000, "R6");

      // R7: left normalization and exact cancellation
      run(32'h3F800001, 32'h3F800000, 1'b1, 32'h34000000, "R7");
      run(32'h3F800000, 32'h3F400000, 1'b1, 32'h3E800000, "R7");
      run(32'hBF800000, 32'h3F800000, 1'b0, 32'h00000000, "R7");

      // R8: carry out
      run(32'h3FFFFFFF, 32'h3FFFFFFF, 1'b0, 32'h407FFFFF, "R8");
      run(32'h3FC00000, 32'h3FC00000, 1'b0, 32'h40400000, "R8");

      // R9: exponent overflow
      run(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, "R9");
      run(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000, "R9");

      // R10: underflow flushes
      run(32'h00800001, 32'h00800000, 1'b1, 32'h00000000, "R10");
      run(32'h00FFFFFF, 32'h00800000, 1'b1, 32'h00000000, "R10");

      // R11: infinity propagation
      run(32'h7F800000, 32'h3F800000, 1'b1, 32'h7F800000, "R11");
      run(32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, "R11");
      run(32'h7F800000, 32'hFF800000, 1'b1, 32'h7F800000, "R11");

      // R12: NaN results
      run(32'h7FC00001, 32'h3F800000, 1'b0, 32'h7FC00000, "R12");
      run(32'h3F800000, 32'hFF800001, 1'b0, 32'h7FC00000, "R12");
      run(32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, "R12");

      // R5 R7 R3: sweep of small integers, both operations
      for (int i = 0; i < 16; i++) begin
         for (int j = 0; j < 16; j++) begin
            for (int s = 0; s < 2; s++) begin
               int m;
               logic [31:0] e;
               m = (s == 1) ? (i - j) : (i + j);
               e = (m < 0) ? {1'b1, enc(-m)[30:0]} : enc(m);
               run(enc(i), enc(j), s[0], e, "R5 sweep");
            end
         end
      end

      in_valid = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule